// File: doc/BRIEF.md
# UART Receive Data Buffer

This block holds characters that a UART receiver has taken off the line until the host reads them. Each stored entry is 12 bits wide: the received byte sits in the low 8 bits and four error bits sit above it. The buffer runs in one of two modes. In queue mode it is a 16-entry circular buffer. In single-slot mode it holds one character. A single mode bit selects the mode, and that bit arrives with each write to the line-control register.

The receiver pushes either a character or a line-break event. The block tells the receiver whether it can take another entry. The host pops entries through a read strobe, and the entry at the head is always visible on the read-data port. The block keeps full and empty flags in a flag byte, a sticky receive-status nibble, and a receive interrupt request that follows a trigger level.

Top module: `uart_rxq`

## Requirements
- R1: After reset the flag byte reads 0x90: bit 7 (transmit empty) and bit 4 (receive empty) are set, and bit 6 (receive full) is clear. The status nibble reads 0, the interrupt request is low, `can_accept` is high, and the buffer is in single-slot mode.
- R2: In queue mode (`lc_fifo_en`=1) the block accepts a push while it holds fewer than 16 entries. In single-slot mode it accepts a push only when it is empty. `can_accept` reports this condition.
- R3: Flag bit 6 (full) is set by an accepted push that leaves 16 entries, or by any accepted push in single-slot mode. Any host read clears bit 6. Flag bit 4 (empty) is clear whenever entries are held and set when the count drops to 0.
- R4: A push that is not accepted is dropped. The stored entries, their order and the flags are unchanged.
- R5: Reads return entries oldest first. Read and write positions wrap from 15 to 0, so the buffer can be cycled through many times.
- R6: A read of an empty buffer returns the entry at the current read position and leaves the positions unchanged.
- R7: Every host read copies bits 11:8 of the returned entry into the status nibble. A status-clear write sets the nibble to 0. If a clear and a read happen in the same cycle, the clear wins.
- R8: A break event stores 0x400, which is bit 10 set and a zero byte. If a break and a character push arrive in the same cycle, the break wins.
- R9: A line-control write that changes the mode bit empties the buffer. The count and read position return to 0, empty is set, and full and the interrupt request are cleared. A push in that same cycle is discarded. A line-control write that leaves the mode bit unchanged has no effect.
- R10: The interrupt request rises when a push brings the count up to the trigger level of 1. It falls when a read leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Receiver offers a character |
| rx_entry | input | 12 | Character in bits 7:0, error bits in 11:8 |
| rx_break | input | 1 | Receiver reports a line break |
| can_accept | output | 1 | Buffer can take a push this cycle |
| host_rd | input | 1 | Host read of the data register (pop) |
| rd_data | output | 12 | Entry at the read position |
| lc_wr | input | 1 | Write to the line-control register |
| lc_fifo_en | input | 1 | Mode bit carried by that write (1 = queue mode) |
| stat_clr | input | 1 | Write to the receive-status register |
| rx_status | output | 4 | Sticky error bits from the last read |
| flags | output | 8 | Flag byte: bit 7 tx empty, bit 6 rx full, bit 4 rx empty |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest state to reach from the ports is a wrapped buffer, where the write position has passed slot 15 while older entries still sit at the high slots. The bench fills all 16 slots and checks that a 17th push is dropped. It then drains five entries, pushes five more so the writes wrap to slots 0 through 4, and reads all 16 back against a model. Mode flushes are also tested while entries are still held, with a push in the same cycle, so that only the flush-wins rule can explain what the next read returns.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  // Flag byte bit positions (decoded by the register block)
  localparam int FLG_TX_EMPTY = 7;
  localparam int FLG_RX_FULL  = 6;
  localparam int FLG_TX_FULL  = 5;
  localparam int FLG_RX_EMPTY = 4;

  // Break marker bit within a stored entry
  localparam int BREAK_BIT = 10;

  // Circular slot arithmetic: base + offs, modulo depth
  function automatic int slot_after(int base, int offs, int depth);
    return (base + offs) % depth;
  endfunction

  // Whether a push can be taken for a given fill count and mode
  function automatic logic accepts(int fill, logic queue_mode, int depth);
    return queue_mode ? (fill < depth) : (fill < 1);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (we && (waddr == PW'(g)))
        slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];

endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          lc_wr,
  input  logic          lc_fifo_en,
  output logic          queue_mode,
  output logic          can_accept,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          flush,
  output logic [PW-1:0] rd_pos,
  output logic [PW-1:0] wr_slot,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_next
);

  logic          mode_q;
  logic [PW-1:0] pos_q, pos_next;
  logic [CW-1:0] cnt_q;

  always_comb begin
    flush      = lc_wr && (lc_fifo_en != mode_q);
    can_accept = accepts(int'(cnt_q), mode_q, DEPTH);
    push_ok    = push_req && can_accept && !flush;
    pop_ok     = pop_req && (cnt_q != '0);
    wr_slot    = PW'(slot_after(int'(pos_q), int'(cnt_q), DEPTH));
    if (flush) begin
      cnt_next = '0;
      pos_next = '0;
    end else begin
      cnt_next = cnt_q + CW'(push_ok) - CW'(pop_ok);
      pos_next = pop_ok ? PW'(slot_after(int'(pos_q), 1, DEPTH)) : pos_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pos_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (lc_wr) mode_q <= lc_fifo_en;
      pos_q <= pos_next;
      cnt_q <= cnt_next;
    end
  end

  assign queue_mode = mode_q;
  assign rd_pos     = pos_q;
  assign cnt        = cnt_q;

  // R2: the count never exceeds the depth of the current mode
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(DEPTH)) && (mode_q || cnt_q <= CW'(1)));

  // R4: a refused push with no other event leaves the count alone
  a_r4_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !can_accept && !pop_req && !lc_wr) |=> $stable(cnt_q));

  // R5: the read position wraps from the last slot to slot 0
  a_r5_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && pos_q == PW'(DEPTH - 1)) |=> (pos_q == '0));

  // R9: a mode change empties the buffer
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && pos_q == '0));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          pop_req,
  input  logic          flush,
  input  logic          queue_mode,
  input  logic [CW-1:0] cnt_next,
  input  logic [3:0]    rd_hi,
  input  logic          stat_clr,
  output logic          full,
  output logic          empty,
  output logic          irq,
  output logic [3:0]    status
);

  logic full_q, empty_q, irq_q;
  logic [3:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
      irq_q    <= 1'b0;
      status_q <= '0;
    end else begin
      if (flush)
        full_q <= 1'b0;
      else if (push_ok)
        full_q <= !queue_mode || (cnt_next == CW'(DEPTH));
      else if (pop_req)
        full_q <= 1'b0;

      if (flush || push_ok || pop_req)
        empty_q <= (cnt_next == '0);

      if (flush)
        irq_q <= 1'b0;
      else if (push_ok && cnt_next == CW'(TRIG))
        irq_q <= 1'b1;
      else if (pop_req && cnt_next == CW'(TRIG - 1))
        irq_q <= 1'b0;

      if (stat_clr)
        status_q <= '0;
      else if (pop_req)
        status_q <= rd_hi;
    end
  end

  assign full   = full_q;
  assign empty  = empty_q;
  assign irq    = irq_q;
  assign status = status_q;

  // R3: a read with no accepted push leaves full clear
  a_r3_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_ok) |=> !full_q);

  // R7: a status-clear write always zeroes the nibble
  a_r7_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (status_q == '0));

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 12,
  parameter int TRIG    = 1,
  localparam int PW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_push,
  input  logic [ENTRY_W-1:0] rx_entry,
  input  logic               rx_break,
  output logic               can_accept,
  input  logic               host_rd,
  output logic [ENTRY_W-1:0] rd_data,
  input  logic               lc_wr,
  input  logic               lc_fifo_en,
  input  logic               stat_clr,
  output logic [3:0]         rx_status,
  output logic [7:0]         flags,
  output logic               rx_irq
);

  // Named internal events
  logic               push_req, push_ok, pop_ok, flush, queue_mode;
  logic [PW-1:0]      rd_pos, wr_slot;
  logic [CW-1:0]      cnt, cnt_next;
  logic [ENTRY_W-1:0] push_word;
  logic               full, empty;

  assign push_req  = rx_push || rx_break;
  assign push_word = rx_break ? ENTRY_W'(1 << BREAK_BIT) : rx_entry;

  rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (push_req),
    .pop_req    (host_rd),
    .lc_wr      (lc_wr),
    .lc_fifo_en (lc_fifo_en),
    .queue_mode (queue_mode),
    .can_accept (can_accept),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .flush      (flush),
    .rd_pos     (rd_pos),
    .wr_slot    (wr_slot),
    .cnt        (cnt),
    .cnt_next   (cnt_next)
  );

  rxq_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (push_ok),
    .waddr (wr_slot),
    .wdata (push_word),
    .raddr (rd_pos),
    .rdata (rd_data)
  );

  rxq_flags #(.DEPTH(DEPTH), .TRIG(TRIG)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_ok    (push_ok),
    .pop_req    (host_rd),
    .flush      (flush),
    .queue_mode (queue_mode),
    .cnt_next   (cnt_next),
    .rd_hi      (rd_data[ENTRY_W-1:8]),
    .stat_clr   (stat_clr),
    .full       (full),
    .empty      (empty),
    .irq        (rx_irq),
    .status     (rx_status)
  );

  always_comb begin
    flags               = '0;
    flags[FLG_TX_EMPTY] = 1'b1;
    flags[FLG_TX_FULL]  = 1'b0;
    flags[FLG_RX_FULL]  = full;
    flags[FLG_RX_EMPTY] = empty;
  end

  // R3: the empty flag agrees with the pointer block's count
  a_r3_empty_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (cnt == '0));

  // R10: the request rises only when the count sits at the trigger level
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> (cnt == CW'(TRIG)));

  // R10: the request is never held while the buffer is empty
  a_r10_irq_low_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !rx_irq);

endmodule

// File: tb/uart_rxq_bench.sv
module uart_rxq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_push = 1'b0;
  logic [11:0] rx_entry = '0;
  logic        rx_break = 1'b0;
  logic        can_accept;
  logic        host_rd = 1'b0;
  logic [11:0] rd_data;
  logic        lc_wr = 1'b0;
  logic        lc_fifo_en = 1'b0;
  logic        stat_clr = 1'b0;
  logic [3:0]  rx_status;
  logic [7:0]  flags;
  logic        rx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  int m_mem[16];
  int m_pos, m_cnt, m_status;
  bit m_fe, m_full, m_empty, m_irq;

  always #4 clk = ~clk;

  uart_rxq u_uart_rxq (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_entry(rx_entry),
    .rx_break(rx_break), .can_accept(can_accept), .host_rd(host_rd),
    .rd_data(rd_data), .lc_wr(lc_wr), .lc_fifo_en(lc_fifo_en),
    .stat_clr(stat_clr), .rx_status(rx_status), .flags(flags), .rx_irq(rx_irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic bit m_can();
    return m_fe ? (m_cnt < 16) : (m_cnt < 1);
  endfunction

  function automatic void m_push(int d);
    if (!m_can()) return;
    m_mem[(m_pos + m_cnt) % 16] = d;
    m_cnt++;
    m_empty = 0;
    if (!m_fe || m_cnt == 16) m_full = 1;
    if (m_cnt == 1) m_irq = 1;
  endfunction

  function automatic int m_pop();
    int v = m_mem[m_pos];
    m_full = 0;
    if (m_cnt > 0) begin
      m_cnt--;
      m_pos = (m_pos + 1) % 16;
    end
    if (m_cnt == 0) begin
      m_empty = 1;
      m_irq = 0;
    end
    m_status = v >> 8;
    return v;
  endfunction

  task automatic compare(string req);
    check({req, " flags"}, flags, {1'b1, m_full, 1'b0, m_empty, 4'b0});
    check({req, " irq"}, rx_irq, m_irq);
    check({req, " status"}, rx_status, m_status);
    check({req, " can_accept"}, can_accept, m_can());
  endtask

  task automatic do_push(int d, bit brk, string req);
    rx_entry = 12'(d);
    rx_push  = 1'b1;
    rx_break = brk;
    m_push(brk ? 'h400 : d);
    step();
    rx_push  = 1'b0;
    rx_break = 1'b0;
    compare(req);
  endtask

  task automatic do_pop(string req);
    int exp = m_pop();
    check({req, " rd_data"}, rd_data, exp);
    host_rd = 1'b1;
    step();
    host_rd = 1'b0;
    compare(req);
  endtask

  task automatic set_mode(bit fe, bit with_push, string req);
    lc_wr = 1'b1;
    lc_fifo_en = fe;
    if (with_push) begin
      rx_push = 1'b1;
      rx_entry = 12'h0EE;
    end
    if (fe != m_fe) begin
      m_cnt = 0; m_pos = 0; m_empty = 1; m_full = 0; m_irq = 0;
    end else if (with_push) begin
      m_push('h0EE);
    end
    m_fe = fe;
    step();
    lc_wr = 1'b0;
    rx_push = 1'b0;
    compare(req);
  endtask

  task automatic t_reset();
    m_pos = 0; m_cnt = 0; m_status = 0; m_fe = 0;
    m_full = 0; m_empty = 1; m_irq = 0;
    foreach (m_mem[i]) m_mem[i] = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 flags reset", flags, 'h90);
    check("R1 status reset", rx_status, 0);
    check("R1 irq reset", rx_irq, 0);
    check("R1 can_accept reset", can_accept, 1);
  endtask

  task automatic t_holding();
    do_push('h241, 0, "R2 R3 R10 single push");
    check("R2 single full", can_accept, 0);
    do_push('h099, 0, "R4 dropped push");
    do_pop("R5 R7 single read");
    check("R7 status from read", rx_status, 2);
  endtask

  task automatic t_fifo_wrap();
    set_mode(1, 0, "R9 enter queue mode");
    for (int i = 0; i < 16; i++)
      do_push(((i % 4) << 8) | (i * 7 + 3), 0, "R2 R3 fill");
    check("R3 full at 16", flags[6], 1);
    do_push('h0CC, 0, "R4 push when full");
    for (int i = 0; i < 5; i++) do_pop("R5 partial drain");
    for (int i = 0; i < 5; i++) do_push('h100 | (i + 'h50), 0, "R5 wrap write");
    for (int i = 0; i < 16; i++) do_pop("R5 wrap drain");
    check("R3 empty after drain", flags[4], 1);
  endtask

  task automatic t_break_status();
    do_push('h0FF, 1, "R8 break wins");
    do_pop("R8 break read");
    check("R8 break status", rx_status, 4);
    stat_clr = 1'b1;
    m_status = 0;
    step();
    stat_clr = 1'b0;
    check("R7 status clear", rx_status, 0);
    do_push('h3AA, 0, "R7 setup");
    void'(m_pop());
    m_status = 0;
    check("R7 read data", rd_data, 'h3AA);
    host_rd = 1'b1;
    stat_clr = 1'b1;
    step();
    host_rd = 1'b0;
    stat_clr = 1'b0;
    compare("R7 clear beats read");
  endtask

  task automatic t_flush();
    for (int i = 0; i < 3; i++) do_push('h010 + i, 0, "R9 preload");
    set_mode(1, 0, "R9 same mode no effect");
    check("R9 no flush keeps data", rd_data, m_mem[m_pos]);
    set_mode(0, 1, "R9 flush with push");
    check("R9 flushed empty", flags[4], 1);
    do_push('h0AB, 0, "R9 push after flush");
    do_pop("R9 read after flush");
  endtask

  task automatic t_empty_read();
    do_pop("R6 empty read");
    do_pop("R6 second empty read");
    do_push('h177, 0, "R6 push after empty read");
    do_pop("R6 read new entry");
  endtask

  initial begin
    t_reset();
    t_holding();
    t_fifo_wrap();
    t_break_status();
    t_flush();
    t_empty_read();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule